// File: doc/BRIEF.md
# Three-Wire Serial Word EEPROM Slave

This block models the device side of a three-wire serial word memory of 256 words by 16 bits. It runs on a fast system clock and oversamples the chip select, serial clock, serial data input and a write-abort pin. The level of the serial clock at the moment chip select falls picks the mode. A high clock opens an instruction frame. A low clock opens a status window that shows whether a program cycle is still running.

An instruction frame has an 8-bit opcode, an 8-bit address and, for writes, 16 data bits, all sent MSB first. Data in is sampled on rising serial clock edges and data out changes on falling edges. A write-enable latch guards the array. A write launches a self-timed busy period, and the word is committed when that period ends. Reads stream words from consecutive addresses for as long as the clock runs, and the address wraps at the top of the array. The serial output is modelled as a data bit plus an output enable. The pins are plain levels, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `wordstore_slave`

## Requirements
- R1: When chip select falls while the synchronised serial clock is high, a frame opens. Each rising serial clock edge shifts one DI bit, first through the 8 opcode bits, then the 8 address bits, then the 16 data bits, each field MSB first.
- R2: When chip select falls while the serial clock is low, status mode starts. The block drives do_oe_o high, and do_o is 1 when ready and 0 while a program cycle runs.
- R3: Status mode ends when chip select rises, or at the first rising clock edge with DI=1. That 1 becomes the first opcode bit of a new frame, provided the block is not busy.
- R4: The opcodes are 8'hA4 (write), 8'hA8 (read), 8'hA3 (set write enable) and 8'hA0 (clear write enable). For the two enable opcodes the address bits have no effect, and further clock pulses in the same frame are ignored.
- R5: After system reset and after a clear-enable instruction, a write neither starts a busy period nor changes the array. Reads work with the latch in either state.
- R6: In a read, the first falling edge after the 16th rising edge drives bit 15 of the addressed word with do_oe_o high. Each later falling edge drives the next lower bit.
- R7: After bit 0 of a word, the read continues with the next address, and address 8'hFF is followed by 8'h00.
- R8: With the latch set, the 32nd rising edge of a write starts a busy period of BUSY_CYCLES system clocks, independent of chip select. The word is stored when that period ends.
- R9: If wr_abort_i is high at any time while a write frame is being received, no busy period starts and the array keeps its contents.
- R10: If wr_abort_i is high during a busy period, busy_o falls on the next clock and the target word becomes all ones.
- R11: Raising chip select before the 32nd rising edge of a write abandons it. do_oe_o is low whenever chip select is high.
- R12: An unknown opcode makes the rest of the frame a no-op, with do_oe_o low until chip select rises.
- R13: A frame opened while busy is ignored, with do_oe_o low. System reset clears the array to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low system reset (power-on) |
| cs_i | input | 1 | Chip select, active low |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| wr_abort_i | input | 1 | Active-high write abort / write protect |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Output enable for do_o (low = high impedance) |
| busy_o | output | 1 | Program cycle in progress |

## Verification
The bench targets the sequential read across the 8'hFF to 8'h00 boundary. A design that fails to wrap would return a word from outside the array or stall. It also aborts a program cycle midway and expects all ones; a design that ignored the abort would store the real data and stay busy. Status entry is checked by feeding a read opcode straight after a low-clock select. Writes are also tried with the latch cleared, with the abort pin high during entry, and cut short by chip select; a design that mishandled the latch, the abort latch or the frame count would then report a busy period or alter a word.

// File: rtl/wstore_pkg.sv
package wstore_pkg;
  localparam int OP_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_STAT,
    ST_READ,
    ST_DONE
  } fr_state_t;

  localparam logic [OP_W-1:0] OPC_WRITE = 8'hA4;
  localparam logic [OP_W-1:0] OPC_READ  = 8'hA8;
  localparam logic [OP_W-1:0] OPC_WEN   = 8'hA3;
  localparam logic [OP_W-1:0] OPC_WDIS  = 8'hA0;

  function automatic logic opcode_known(input logic [OP_W-1:0] op);
    return (op == OPC_WRITE) || (op == OPC_READ) ||
           (op == OPC_WEN) || (op == OPC_WDIS);
  endfunction
endpackage

// File: rtl/wstore_sync.sv
module wstore_sync #(
  parameter int STAGES = 2,
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_prev_o <= RST_VAL;
    else        q_prev_o <= chain[STAGES-1];
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wstore_array.sv
module wstore_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/wstore_prog.sv
module wstore_prog #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BUSY_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int TW = $clog2(BUSY_CYCLES + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(BUSY_CYCLES - 1);

  logic [TW-1:0]     tmr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      we_o    <= 1'b0;
      tmr_q   <= '0;
      waddr_o <= '0;
      data_q  <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (busy_o) begin
        if (abort_i) begin
          busy_o  <= 1'b0;
          we_o    <= 1'b1;
          wdata_o <= '1;
        end else if (tmr_q == '0) begin
          busy_o  <= 1'b0;
          we_o    <= 1'b1;
          wdata_o <= data_q;
        end else begin
          tmr_q <= tmr_q - 1'b1;
        end
      end else if (start_i) begin
        busy_o  <= 1'b1;
        tmr_q   <= T_LOAD;
        waddr_o <= addr_i;
        data_q  <= data_i;
      end
    end
  end
endmodule

// File: rtl/wstore_frame.sv
module wstore_frame
  import wstore_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sk_s,
  input  logic              di_s,
  input  logic              abort_s,
  input  logic              cs_fall,
  input  logic              sk_rise,
  input  logic              sk_fall,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_start_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              do_o,
  output logic              do_oe_o,
  output fr_state_t         st_o,
  output logic              wen_o
);
  localparam int FRAME_LEN = OP_W + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] OP_END  = CNT_W'(OP_W);
  localparam logic [CNT_W-1:0] AD_END  = CNT_W'(OP_W + ADDR_W);
  localparam logic [CNT_W-1:0] OP_LAST = CNT_W'(OP_W - 1);
  localparam logic [CNT_W-1:0] AD_LAST = CNT_W'(OP_W + ADDR_W - 1);
  localparam logic [CNT_W-1:0] FR_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(DATA_W - 1);

  fr_state_t         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BIT_W-1:0]  bit_q;
  logic              abort_seen_q;
  logic              do_q;
  logic              oe_q;

  logic [OP_W-1:0]   op_next;
  logic [ADDR_W-1:0] addr_next;
  logic [DATA_W-1:0] data_next;

  assign op_next   = {op_q[OP_W-2:0], di_s};
  assign addr_next = {addr_q[ADDR_W-2:0], di_s};
  assign data_next = {data_q[DATA_W-2:0], di_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      cnt_q        <= '0;
      op_q         <= '0;
      addr_q       <= '0;
      data_q       <= '0;
      bit_q        <= '0;
      rd_addr_o    <= '0;
      abort_seen_q <= 1'b0;
      do_q         <= 1'b0;
      oe_q         <= 1'b0;
      wen_o        <= 1'b0;
      wr_start_o   <= 1'b0;
    end else begin
      wr_start_o <= 1'b0;
      if (cs_s) begin
        st_q  <= ST_IDLE;
        oe_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (cs_fall) begin
              cnt_q        <= '0;
              abort_seen_q <= abort_s;
              if (!sk_s)       st_q <= ST_STAT;
              else if (busy_i) st_q <= ST_DONE;
              else             st_q <= ST_CMD;
            end
          end
          ST_STAT: begin
            if (sk_rise && di_s) begin
              if (busy_i) begin
                st_q <= ST_DONE;
              end else begin
                st_q         <= ST_CMD;
                op_q         <= op_next;
                cnt_q        <= CNT_W'(1);
                abort_seen_q <= abort_s;
              end
            end
          end
          ST_CMD: begin
            if (abort_s) abort_seen_q <= 1'b1;
            if (sk_rise) begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q < OP_END)      op_q   <= op_next;
              else if (cnt_q < AD_END) addr_q <= addr_next;
              else                     data_q <= data_next;

              if (cnt_q == OP_LAST && !opcode_known(op_next)) st_q <= ST_DONE;

              if (cnt_q == AD_LAST) begin
                if (op_q == OPC_READ) begin
                  st_q      <= ST_READ;
                  rd_addr_o <= addr_next;
                  bit_q     <= TOP_BIT;
                end else if (op_q == OPC_WEN) begin
                  wen_o <= 1'b1;
                  st_q  <= ST_DONE;
                end else if (op_q == OPC_WDIS) begin
                  wen_o <= 1'b0;
                  st_q  <= ST_DONE;
                end
              end

              if (cnt_q == FR_LAST) begin
                st_q <= ST_DONE;
                if (wen_o && !abort_seen_q && !abort_s) wr_start_o <= 1'b1;
              end
            end
          end
          ST_READ: begin
            if (sk_fall) begin
              do_q <= rd_word_i[bit_q];
              oe_q <= 1'b1;
              if (bit_q == '0) begin
                bit_q     <= TOP_BIT;
                rd_addr_o <= rd_addr_o + 1'b1;
              end else begin
                bit_q <= bit_q - 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
  assign st_o      = st_q;
  assign do_o      = (st_q == ST_STAT) ? !busy_i : do_q;
  assign do_oe_o   = (st_q == ST_STAT) || oe_q;
endmodule

// File: rtl/wordstore_slave.sv
module wordstore_slave
  import wstore_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BUSY_CYCLES = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic wr_abort_i,
  output logic do_o,
  output logic do_oe_o,
  output logic busy_o
);
  logic [3:0] pin_s, pin_p;
  logic cs_s, sk_s, di_s, abort_s, cs_fall, sk_rise, sk_fall;

  wstore_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({cs_i, sk_i, di_i, wr_abort_i}),
    .q_o(pin_s), .q_prev_o(pin_p)
  );

  assign cs_s    = pin_s[3];
  assign sk_s    = pin_s[2];
  assign di_s    = pin_s[1];
  assign abort_s = pin_s[0];
  assign cs_fall = !pin_s[3] && pin_p[3];
  assign sk_rise = pin_s[2] && !pin_p[2];
  assign sk_fall = !pin_s[2] && pin_p[2];

  logic [ADDR_W-1:0] rd_addr, wr_addr, mem_waddr;
  logic [DATA_W-1:0] rd_word, wr_data, mem_wdata;
  logic              wr_start, mem_we, wen;
  fr_state_t         st;

  wstore_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_s(cs_s), .sk_s(sk_s), .di_s(di_s), .abort_s(abort_s),
    .cs_fall(cs_fall), .sk_rise(sk_rise), .sk_fall(sk_fall),
    .busy_i(busy_o), .rd_word_i(rd_word), .rd_addr_o(rd_addr),
    .wr_start_o(wr_start), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .do_o(do_o), .do_oe_o(do_oe_o), .st_o(st), .wen_o(wen)
  );

  wstore_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n),
    .start_i(wr_start), .addr_i(wr_addr), .data_i(wr_data), .abort_i(abort_s),
    .busy_o(busy_o), .we_o(mem_we), .waddr_o(mem_waddr), .wdata_o(mem_wdata)
  );

  wstore_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i(rd_addr), .rdata_o(rd_word)
  );
endmodule

// File: rtl/wordstore_chk.sv
module wordstore_chk
  import wstore_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cs_s,
  input logic      abort_s,
  input fr_state_t st,
  input logic      busy,
  input logic      wen,
  input logic      oe
);
  assert_deselect_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s && $past(cs_s) |-> !oe);

  assert_busy_needs_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));

  assert_abort_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && abort_s |=> !busy);

  assert_latch_from_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen) |-> $past(st == ST_CMD));

  assert_no_read_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> st != ST_READ);

  assert_done_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_DONE |-> !oe);
endmodule

bind wordstore_slave wordstore_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .abort_s(abort_s),
  .st(st), .busy(busy_o), .wen(wen), .oe(do_oe_o)
);

// File: tb/wordstore_slave_tb_top.sv
module wordstore_slave_tb_top;
  localparam int BUSY = 50;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b1, sk = 1'b1, di = 1'b0, abort = 1'b0;
  logic dout, doe, busy;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wordstore_slave #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .wr_abort_i(abort), .do_o(dout), .do_oe_o(doe), .busy_o(busy)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic open_frame(input bit sk_level);
    cs = 1'b1; sk = sk_level; tick(HP);
    cs = 1'b0; tick(HP);
  endtask

  task automatic close_frame();
    cs = 1'b1; sk = 1'b1; di = 1'b0; tick(2 * HP);
  endtask

  task automatic shift_in(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sk = 1'b0; di = v[i]; tick(HP);
      sk = 1'b1; tick(HP);
    end
  endtask

  task automatic grab(output logic [15:0] w, output bit oe_all, output bit oe_any);
    w = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 0; i < 16; i++) begin
      sk = 1'b0; tick(HP);
      w = {w[14:0], dout};
      oe_all &= doe; oe_any |= doe;
      sk = 1'b1; tick(HP);
    end
  endtask

  task automatic cmd_wen();
    open_frame(1'b1); shift_in({8'hA3, 8'h5A}, 16); close_frame();
  endtask

  task automatic cmd_wdis();
    open_frame(1'b1); shift_in({8'hA0, 8'hC3}, 16); close_frame();
  endtask

  task automatic cmd_write(input logic [7:0] a, input logic [15:0] d);
    open_frame(1'b1); shift_in({8'hA4, a, d}, 32); close_frame();
  endtask

  task automatic read_word(input logic [7:0] a, output logic [15:0] w, output bit oe_all);
    bit oe_any;
    open_frame(1'b1); shift_in({8'hA8, a}, 16);
    grab(w, oe_all, oe_any);
    close_frame();
  endtask

  task automatic wait_done();
    tick(BUSY + 20);
  endtask

  task automatic t_reset();
    logic [15:0] w; bit oa;
    chk(!doe, "R11", "oe after reset", doe, 0);
    chk(!busy, "R13", "busy after reset", busy, 0);
    read_word(8'h07, w, oa);
    chk(w == 16'h0000 && oa, "R13", "array cleared by reset", w, 0);
  endtask

  task automatic t_write_blocked();
    logic [15:0] w; bit oa;
    cmd_write(8'h12, 16'hBEEF);
    chk(!busy, "R5", "no busy with latch clear", busy, 0);
    wait_done();
    read_word(8'h12, w, oa);
    chk(w == 16'h0000, "R5", "word unchanged, read still works", w, 0);
  endtask

  task automatic t_write_and_status();
    logic [15:0] w; bit oa;
    cmd_wen();
    open_frame(1'b1); shift_in({8'hA4, 8'h12, 16'hBEEF}, 32);
    chk(busy, "R8", "busy after 32nd edge", busy, 1);
    close_frame();
    open_frame(1'b0);
    chk(doe && !dout, "R2", "status shows busy", {doe, dout}, 2'b10);
    close_frame();
    chk(!doe, "R11", "status released by cs", doe, 0);
    wait_done();
    chk(!busy, "R8", "busy ends", busy, 0);
    open_frame(1'b0);
    chk(doe && dout, "R2", "status shows ready", {doe, dout}, 2'b11);
    close_frame();
    read_word(8'h12, w, oa);
    chk(w == 16'hBEEF && oa, "R6", "read back D15 first", w, 16'hBEEF);
  endtask

  task automatic t_status_exit();
    logic [15:0] w; bit oa, on;
    open_frame(1'b0);
    chk(doe && dout, "R3", "status before first bit", {doe, dout}, 2'b11);
    shift_in({8'hA8, 8'h12}, 16);
    grab(w, oa, on);
    close_frame();
    chk(w == 16'hBEEF, "R3", "status hands over to read frame", w, 16'hBEEF);
    chk(oa, "R1", "read output enabled", oa, 1);
  endtask

  task automatic t_wrap_read();
    logic [15:0] w0, w1; bit oa0, oa1, on;
    cmd_write(8'hFF, 16'h1234); wait_done();
    cmd_write(8'h00, 16'hA5C3); wait_done();
    open_frame(1'b1); shift_in({8'hA8, 8'hFF}, 16);
    grab(w0, oa0, on); grab(w1, oa1, on);
    close_frame();
    chk(w0 == 16'h1234, "R7", "word at FF", w0, 16'h1234);
    chk(w1 == 16'hA5C3 && oa1, "R7", "wrap to 00", w1, 16'hA5C3);
  endtask

  task automatic t_wdis();
    logic [15:0] w; bit oa;
    cmd_wdis();
    cmd_write(8'h20, 16'h5555);
    chk(!busy, "R5", "write blocked after clear", busy, 0);
    wait_done();
    read_word(8'h20, w, oa);
    chk(w == 16'h0000, "R5", "word 20 untouched", w, 0);
    open_frame(1'b1); shift_in({8'hA3, 8'h00, 16'hFFFF}, 32); close_frame();
    cmd_write(8'h21, 16'h0F0F);
    chk(busy, "R4", "enable with extra pulses still works", busy, 1);
    wait_done();
    read_word(8'h21, w, oa);
    chk(w == 16'h0F0F, "R4", "word 21 written", w, 16'h0F0F);
  endtask

  task automatic t_abort_entry();
    logic [15:0] w; bit oa;
    open_frame(1'b1);
    shift_in({8'hA4, 8'h12}, 16);
    abort = 1'b1; shift_in(32'h0000_6666, 4); abort = 1'b0;
    shift_in(32'h0000_0666, 12);
    chk(!busy, "R9", "no busy after abort in entry", busy, 0);
    close_frame(); wait_done();
    read_word(8'h12, w, oa);
    chk(w == 16'hBEEF, "R9", "word kept", w, 16'hBEEF);
  endtask

  task automatic t_abort_busy();
    logic [15:0] w; bit oa;
    cmd_write(8'h30, 16'h1111);
    chk(busy, "R10", "busy before abort", busy, 1);
    abort = 1'b1; tick(6);
    chk(!busy, "R10", "busy dropped by abort", busy, 0);
    abort = 1'b0; tick(4);
    read_word(8'h30, w, oa);
    chk(w == 16'hFFFF, "R10", "aborted word all ones", w, 16'hFFFF);
  endtask

  task automatic t_cs_midframe();
    logic [15:0] w; bit oa;
    open_frame(1'b1); shift_in({8'hA4, 8'h40, 4'h9}, 20);
    close_frame();
    chk(!busy && !doe, "R11", "abandoned write idle", {busy, doe}, 0);
    read_word(8'h40, w, oa);
    chk(w == 16'h0000, "R11", "word 40 untouched", w, 0);
  endtask

  task automatic t_bad_op();
    logic [15:0] w; bit oa, on;
    open_frame(1'b1); shift_in({8'h55, 8'h12}, 16);
    grab(w, oa, on);
    chk(!on && !busy, "R12", "unknown opcode silent", {on, busy}, 0);
    close_frame();
  endtask

  task automatic t_cmd_while_busy();
    logic [15:0] w; bit oa, on;
    cmd_write(8'h50, 16'hC0DE);
    open_frame(1'b1); shift_in({8'hA8, 8'h12}, 16);
    grab(w, oa, on);
    close_frame();
    chk(!on, "R13", "frame ignored while busy", on, 0);
    wait_done();
    read_word(8'h50, w, oa);
    chk(w == 16'hC0DE, "R8", "write survives ignored frame", w, 16'hC0DE);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write_blocked();
    t_write_and_status();
    t_status_exit();
    t_wrap_read();
    t_wdis();
    t_abort_entry();
    t_abort_busy();
    t_cs_midframe();
    t_bad_op();
    t_cmd_while_busy();
    summary();
    $finish;
  end
endmodule